// File: doc/BRIEF.md
# Interrupt Coalescing Threshold and Delay Unit

This unit moderates completion interrupts for one transfer channel. It keeps a countdown of finished packets. The countdown is loaded from a programmable threshold. When enough packets have completed, the unit sets a sticky completion flag and loads the countdown again. The unit also has an inactivity timer. The timer is armed afresh by every completion when the programmed delay is nonzero. When no new completion arrives before the timer runs out, the unit sets a sticky delay flag and reloads the packet countdown. Software-facing logic decodes the control register, pulses the reload strobe on each control write and masks the two flags into interrupt lines. The live countdown and the timer value are given out for status readback.

The timer is a two-state machine. In `TMR_IDLE` it holds zero. The transition `arm` (a completion with a nonzero delay) moves it to `TMR_RUN`. In `TMR_RUN` the transitions are:
- `rearm`: a completion with a nonzero delay. The timer stays in `TMR_RUN` and reloads the delay.
- `tick`: the timer decrements while its value is above one.
- `expire`: a tick while the value is one. The timer returns to `TMR_IDLE`.

Top module: `ic_coalesce`

## Requirements
- R1: After reset both flags are 0, the countdown reads `RST_COUNT` (default 1) and the timer reads 0.
- R2: A cycle with `reload` high loads the countdown from `thresh` at the next edge. This takes precedence over a completion in the same cycle, and that completion is not counted.
- R3: Each `pkt_done` cycle without reload or expiry decrements the countdown. If the decremented value is 0, the countdown loads `thresh` instead and `cmp_flag` is set.
- R4: A threshold of 0 gives exactly 256 completions between completion-flag settings, because the countdown wraps from 0 to 255.
- R5: A completion with a nonzero `delay` loads the timer with `delay` at the next edge. This happens whether the timer is idle or running, and a tick in the same cycle is ignored.
- R6: A completion with `delay` equal to 0 neither starts nor restarts the timer. A running timer continues its countdown.
- R7: A running timer decrements by one only in cycles where `tick` is high. Otherwise it holds its value. An idle timer reads 0.
- R8: A tick while the timer reads 1, with no rearming completion, is an expiry. The timer goes to 0, `dly_flag` is set and the countdown loads `thresh`. The expiry takes precedence over a completion in the same cycle, and that completion is not counted.
- R9: `clr_cmp` and `clr_dly` clear their flag at the next edge. If a set event for the same flag occurs in the same cycle, the set wins.
- R10: Each flag stays set until its clear strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle end-of-packet completion pulse |
| thresh | input | CNT_W | Completion threshold (0 means 256) |
| delay | input | DLY_W | Inactivity delay in ticks (0 disables) |
| reload | input | 1 | Strobe on each control write; reloads the countdown |
| tick | input | 1 | Timer time-base enable |
| clr_cmp | input | 1 | Clear strobe for the completion flag |
| clr_dly | input | 1 | Clear strobe for the delay flag |
| cmp_flag | output | 1 | Sticky completion-threshold flag |
| dly_flag | output | 1 | Sticky delay-expiry flag |
| countdown | output | CNT_W | Current completion countdown |
| timer_cnt | output | DLY_W | Current delay timer value |

## Verification
The properties assume that every input is 0 or 1 at each edge after reset. They also assume that `thresh` and `delay` are sampled in the same cycle as the strobe that uses them. The properties treat a high strobe as one event per cycle, so they do not rely on a strobe being a single-cycle pulse.

The stimulus drives all inputs from one task, just after a clock edge. It changes `thresh` and `delay` only together with a reload or between packets. It sweeps thresholds and delays over small ranges and adds the 256 wrap. Strobes are deliberately overlapped to reach the precedence cases:
- reload together with a completion,
- expiry together with a completion,
- set together with clear.

// File: rtl/ic_pkg.sv
package ic_pkg;
    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_CMP  = 0;
    localparam int FLAG_DLY  = 1;
endpackage

// File: rtl/ic_pkt_counter.sv
module ic_pkt_counter #(
    parameter int CNT_W     = 8,
    parameter int RST_COUNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             expire,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_VAL  = CNT_W'(RST_COUNT);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] dec;

    assign dec = count_q - ONE;

    always_comb begin
        count_d = count_q;
        hit     = 1'b0;
        if (reload || expire) begin
            count_d = thresh;
        end else if (pkt_done) begin
            if (dec == '0) begin
                hit     = 1'b1;
                count_d = thresh;
            end else begin
                count_d = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RST_VAL;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ic_delay_timer.sv
module ic_delay_timer
    import ic_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [DLY_W-1:0] delay,
    input  logic             tick,
    output logic [DLY_W-1:0] count,
    output logic             expire,
    output logic             running
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    tmr_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             rearm;

    assign rearm = pkt_done && (delay != '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (rearm) begin
                    state_d = TMR_RUN;
                    cnt_d   = delay;
                end
            end
            TMR_RUN: begin
                if (rearm) begin
                    cnt_d = delay;
                end else if (tick) begin
                    if (cnt_q == ONE) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                        expire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                state_d = TMR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign count   = cnt_q;
    assign running = (state_q == TMR_RUN);
endmodule

// File: rtl/ic_sticky_flag.sv
module ic_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/ic_coalesce.sv
module ic_coalesce
    import ic_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DLY_W     = 8,
    parameter int RST_COUNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] thresh,
    input  logic [DLY_W-1:0] delay,
    input  logic             reload,
    input  logic             tick,
    input  logic             clr_cmp,
    input  logic             clr_dly,
    output logic             cmp_flag,
    output logic             dly_flag,
    output logic [CNT_W-1:0] countdown,
    output logic [DLY_W-1:0] timer_cnt
);
    logic                 tmr_expire;
    logic                 tmr_running;
    logic                 cnt_hit;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    ic_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_done (pkt_done),
        .delay    (delay),
        .tick     (tick),
        .count    (timer_cnt),
        .expire   (tmr_expire),
        .running  (tmr_running)
    );

    ic_pkt_counter #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .expire   (tmr_expire),
        .pkt_done (pkt_done),
        .thresh   (thresh),
        .count    (countdown),
        .hit      (cnt_hit)
    );

    assign flag_set[FLAG_CMP] = cnt_hit;
    assign flag_set[FLAG_DLY] = tmr_expire;
    assign flag_clr[FLAG_CMP] = clr_cmp;
    assign flag_clr[FLAG_DLY] = clr_dly;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        ic_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .flag  (flag_q[g])
        );
    end

    assign cmp_flag = flag_q[FLAG_CMP];
    assign dly_flag = flag_q[FLAG_DLY];
endmodule

// File: rtl/ic_coalesce_chk.sv
module ic_coalesce_chk #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_done,
    input logic [CNT_W-1:0] thresh,
    input logic [DLY_W-1:0] delay,
    input logic             reload,
    input logic             tick,
    input logic             clr_cmp,
    input logic             clr_dly,
    input logic             cmp_flag,
    input logic             dly_flag,
    input logic [CNT_W-1:0] countdown,
    input logic [DLY_W-1:0] timer_cnt
);
    localparam logic [DLY_W-1:0] T_ONE = DLY_W'(1);

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> countdown == $past(thresh));

    p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && delay != '0) |=> timer_cnt == $past(delay));

    p_no_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && delay == '0 && !tick) |=> $stable(timer_cnt));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(pkt_done && delay != '0)) |=> $stable(timer_cnt));

    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && timer_cnt == T_ONE && !(pkt_done && delay != '0))
            |=> (dly_flag && timer_cnt == '0 && countdown == $past(thresh)));

    p_clear_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmp && !pkt_done) |=> !cmp_flag);

    p_sticky_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !clr_cmp) |=> cmp_flag);

    p_sticky_dly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_flag && !clr_dly) |=> dly_flag);
endmodule

bind ic_coalesce ic_coalesce_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_done  (pkt_done),
    .thresh    (thresh),
    .delay     (delay),
    .reload    (reload),
    .tick      (tick),
    .clr_cmp   (clr_cmp),
    .clr_dly   (clr_dly),
    .cmp_flag  (cmp_flag),
    .dly_flag  (dly_flag),
    .countdown (countdown),
    .timer_cnt (timer_cnt)
);

// File: tb/ic_coalesce_bench.sv
module ic_coalesce_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_done = 1'b0;
    logic [7:0] thresh = 8'd0;
    logic [7:0] delay = 8'd0;
    logic       reload = 1'b0;
    logic       tick = 1'b0;
    logic       clr_cmp = 1'b0;
    logic       clr_dly = 1'b0;
    logic       cmp_flag, dly_flag;
    logic [7:0] countdown, timer_cnt;

    int n_chk = 0;
    int n_fail = 0;

    int m_cd = 1;
    int m_tm = 0;
    bit m_cf = 0;
    bit m_df = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ic_coalesce u_ic_coalesce (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .thresh(thresh),
        .delay(delay), .reload(reload), .tick(tick), .clr_cmp(clr_cmp),
        .clr_dly(clr_dly), .cmp_flag(cmp_flag), .dly_flag(dly_flag),
        .countdown(countdown), .timer_cnt(timer_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive strobes, advance the expected state, compare after the edge.
    task automatic step(input bit p, input bit rl, input bit tk, input bit cc, input bit cd);
        bit exp_hit;
        bit exp_exp;
        int tm_n;
        int cd_n;
        int dec;
        pkt_done = p; reload = rl; tick = tk; clr_cmp = cc; clr_dly = cd;
        exp_hit = 0; exp_exp = 0; tm_n = m_tm; cd_n = m_cd;
        if (p && delay != 0) tm_n = delay;
        else if (m_tm != 0 && tk) begin
            if (m_tm == 1) exp_exp = 1;
            tm_n = m_tm - 1;
        end
        if (rl || exp_exp) cd_n = thresh;
        else if (p) begin
            dec = (m_cd + 255) % 256;
            if (dec == 0) begin exp_hit = 1; cd_n = thresh; end
            else cd_n = dec;
        end
        m_tm = tm_n; m_cd = cd_n;
        m_cf = exp_hit ? 1'b1 : (cc ? 1'b0 : m_cf);
        m_df = exp_exp ? 1'b1 : (cd ? 1'b0 : m_df);
        @(posedge clk); #1;
        pkt_done = 0; reload = 0; tick = 0; clr_cmp = 0; clr_dly = 0;
        chk("R3 countdown", int'(countdown), m_cd);
        chk("R7 timer", int'(timer_cnt), m_tm);
        chk("R9 cmp_flag", int'(cmp_flag), int'(m_cf));
        chk("R8 dly_flag", int'(dly_flag), int'(m_df));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pk;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 countdown", int'(countdown), 1);
        chk("R1 timer", int'(timer_cnt), 0);
        chk("R1 cmp_flag", int'(cmp_flag), 0);
        chk("R1 dly_flag", int'(dly_flag), 0);

        // Threshold sweep with the timer disabled.
        for (int t = 1; t <= 8; t++) begin
            thresh = 8'(t); delay = 8'd0;
            step(0, 1, 0, 1, 0);
            chk("R2 reload", int'(countdown), t);
            for (int k = 0; k < 2 * t + 1; k++) begin
                step(1, 0, k[0], 0, 0);
                if (k % 3 == 2) step(0, 0, 1, 0, 0);
            end
            step(0, 0, 0, 1, 0);
        end

        // R4: threshold 0 counts 256 completions.
        thresh = 8'd0;
        step(0, 1, 0, 1, 0);
        for (int k = 0; k < 255; k++) step(1, 0, 0, 0, 0);
        chk("R4 no flag at 255", int'(cmp_flag), 0);
        step(1, 0, 0, 0, 0);
        chk("R4 flag at 256", int'(cmp_flag), 1);
        chk("R4 countdown wrap", int'(countdown), 0);

        // R10: flag stays set without clear.
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0);
        chk("R10 sticky cmp", int'(cmp_flag), 1);
        step(0, 0, 0, 1, 0);

        // Delay sweep with varied tick spacing.
        thresh = 8'd5;
        for (int d = 1; d <= 5; d++) begin
            delay = 8'(d);
            step(0, 1, 0, 0, 1);
            step(1, 0, 1, 0, 0);
            chk("R5 arm", int'(timer_cnt), d);
            for (int k = 0; k < 3 * d + 2; k++) step(0, 0, (k % d) != 1, 0, 0);
            chk("R8 expired", int'(dly_flag), 1);
            step(0, 0, 0, 0, 1);
        end

        // R5 rearm while running; R7 hold without tick.
        delay = 8'd4;
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R7 hold", int'(timer_cnt), 3);
        step(1, 0, 1, 0, 0);
        chk("R5 rearm", int'(timer_cnt), 4);

        // R6: zero delay leaves a running timer counting.
        delay = 8'd0;
        step(1, 0, 1, 0, 0);
        chk("R6 keeps running", int'(timer_cnt), 3);
        for (int k = 0; k < 3; k++) step(0, 0, 1, 0, 0);
        chk("R6 expired", int'(dly_flag), 1);

        // R8: expiry with a completion; R9 set wins over clear.
        delay = 8'd2; thresh = 8'd3;
        step(0, 1, 0, 0, 1);
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        delay = 8'd0;
        step(1, 0, 1, 0, 1);
        chk("R8 expiry precedes packet", int'(countdown), 3);
        chk("R9 set beats clear dly", int'(dly_flag), 1);

        // R2: reload beats a completion.
        step(1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        chk("R2 reload beats packet", int'(countdown), 3);

        // R9: completion hit with clear in the same cycle.
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        pk = int'(cmp_flag);
        step(1, 0, 0, 1, 0);
        chk("R9 set beats clear cmp", int'(cmp_flag), 1);
        step(0, 0, 0, 1, 1);
        chk("R9 clear cmp", int'(cmp_flag), 0);
        chk("R9 clear dly", int'(dly_flag), 0);
        chk("R10 prior state", pk, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule